// File: doc/BRIEF.md
# Start/Stop BCD Seconds Timer

This block keeps an elapsed-seconds count from 00 to 59 as two binary-coded decimal digits: a units digit that runs 0 to 9 and a tens digit that runs 0 to 5. The count moves forward by one on each single-cycle seconds strobe, but only while a run flag is set. A start/stop pulse inverts the run flag, so one button event both starts and stops the timer. A separate clear pulse zeroes the count.

Everything is clocked on one system clock. The seconds strobe and the carry into the tens digit act as clock enables, so both digits change on the same edge. Seven-segment decoding, generation of the seconds strobe and debouncing are done elsewhere. All pulse inputs are assumed to be clean and one cycle wide.

Top module: `elapsed_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both digits become 0 and the run flag becomes 0 at that edge.
- R2: A `toggle_i` pulse inverts `running_o` at the next edge. A strobe in that same cycle is judged against the run flag as it was before the edge.
- R3: A `tick_i` strobe while `running_o` is 0 leaves both digits unchanged.
- R4: A strobe while running and with units below 9 raises the units digit by one and leaves the tens digit unchanged.
- R5: A strobe while running and with units at 9 (units bits 3 and 0 both high) sets units to 0 and advances tens by one. From tens 5 the tens digit returns to 0, so 59 becomes 00. In all other cycles the tens digit holds.
- R6: The units digit never exceeds 9 and the tens digit never exceeds 5, not even for one cycle.
- R7: A `clear_i` pulse sets both digits to 0 at the next edge. It takes precedence over a strobe in the same cycle and has no effect on the run flag, so a toggle in the same cycle is still applied.
- R8: On a carry, units and tens take their new values on the same clock edge. For example, 09 becomes 10 with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle seconds strobe |
| toggle_i | input | 1 | One-cycle start/stop pulse |
| clear_i | input | 1 | One-cycle pulse that zeroes the count |
| units_o | output | 4 | Units digit, BCD 0 to 9 |
| tens_o | output | 4 | Tens digit, BCD 0 to 5 |
| running_o | output | 1 | Run flag |

## Verification
The bench applies more than 130 strobes with stop intervals and idle cycles between them. After every cycle it compares both digits with a count modulo 60, so each 9-to-0 carry and several 59-to-00 wraps are checked. A design that decoded the wrap one step late would show 10 or 6 for one cycle. A design that carried on any units value with bit 0 set would make tens run fast. A design that gated the tens clock would leave the tens digit one cycle behind the units digit. The bench also issues strobes while stopped, a clear together with a strobe, a clear together with a toggle, and a toggle together with a strobe. These catch a design that counts while stopped, lets the strobe win over the clear, resets the run flag on clear, or samples the new run flag too early.

// File: rtl/elapsed_timer_pkg.sv
// Shared types for the elapsed-seconds timer.
// Assumes one BCD digit fits in DIGIT_W bits.
package elapsed_timer_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_digit.sv
// One decimal digit slice that counts 0..LAST and wraps to 0.
// Assumes the value never exceeds LAST. Under that assumption, "all bits set in
// LAST are high" can only be true at LAST itself, so the wrap decode needs just
// those bits (bits 3 and 0 when LAST is 9).
module bcd_digit #(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         at_last
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    // Wrap detect: every bit that is set in LAST is high in value.
    always_comb at_last = ((value & LAST_V) == LAST_V);

    // Digit register: reset and clear win, then step with wrap at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            value <= '0;
        else if (step)
            value <= at_last ? '0 : value + W'(1);
    end
endmodule

// File: rtl/run_toggle.sv
// Run flag that inverts on each start/stop pulse.
// Assumes the pulse is one cycle wide. Comes out of reset cleared.
module run_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    output logic run
);
    // Flag register: cleared by reset, inverted by a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (toggle)
            run <= ~run;
    end
endmodule

// File: rtl/elapsed_timer.sv
// 00..59 elapsed-seconds timer made of a chain of BCD digit slices.
// Assumes clean single-cycle tick, toggle and clear pulses on clk. The tick,
// qualified by the run flag, is the clock enable of the lowest digit. Each
// higher digit is enabled when every digit below it is at its last value.
module elapsed_timer #(
    parameter int UNITS_LAST = 9,
    parameter int TENS_LAST  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       toggle_i,
    input  logic       clear_i,
    output logic [3:0] units_o,
    output logic [3:0] tens_o,
    output logic       running_o
);
    import elapsed_timer_pkg::*;

    localparam int NUM_DIGITS = 2;

    logic   run;
    digit_t dig_val  [NUM_DIGITS];
    logic   dig_last [NUM_DIGITS];
    logic   dig_step [NUM_DIGITS];

    run_toggle u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (toggle_i),
        .run    (run)
    );

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        localparam int LIM = (g == 0) ? UNITS_LAST : TENS_LAST;

        if (g == 0) begin : g_low
            // Lowest digit steps on a tick while running.
            assign dig_step[g] = tick_i & run;
        end else begin : g_high
            // Higher digit steps when the digit below wraps.
            assign dig_step[g] = dig_step[g-1] & dig_last[g-1];
        end

        bcd_digit #(.W(DIGIT_W), .LAST(LIM)) u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clear_i),
            .step    (dig_step[g]),
            .value   (dig_val[g]),
            .at_last (dig_last[g])
        );
    end

    // Output mapping.
    assign units_o   = dig_val[0];
    assign tens_o    = dig_val[1];
    assign running_o = run;
endmodule

// File: rtl/elapsed_timer_sva.sv
// Port-level checker for elapsed_timer, attached with bind below.
// Assumes the default limits of 9 and 5.
module elapsed_timer_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       toggle_i,
    input logic       clear_i,
    input logic [3:0] units_o,
    input logic [3:0] tens_o,
    input logic       running_o
);
    logic adv;
    assign adv = tick_i && running_o && !clear_i;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (units_o == 4'd0 && tens_o == 4'd0 && !running_o));

    assert_toggle_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_i |=> (running_o != $past(running_o)));

    assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !clear_i) |=> ($stable(units_o) && $stable(tens_o)));

    assert_units_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && units_o != 4'd9) |=>
            (units_o == $past(units_o) + 4'd1 && $stable(tens_o)));

    assert_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && units_o == 4'd9) |=>
            (units_o == 4'd0 &&
             tens_o == (($past(tens_o) == 4'd5) ? 4'd0 : $past(tens_o) + 4'd1)));

    assert_tens_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !(adv && units_o == 4'd9)) |=> $stable(tens_o));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (units_o <= 4'd9 && tens_o <= 4'd5));

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (units_o == 4'd0 && tens_o == 4'd0));

    assert_clear_keeps_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !toggle_i) |=> $stable(running_o));
endmodule

bind elapsed_timer elapsed_timer_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .toggle_i  (toggle_i),
    .clear_i   (clear_i),
    .units_o   (units_o),
    .tens_o    (tens_o),
    .running_o (running_o)
);

// File: tb/elapsed_timer_bench.sv
module elapsed_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       toggle_i = 1'b0;
    logic       clear_i = 1'b0;
    logic [3:0] units_o;
    logic [3:0] tens_o;
    logic       running_o;

    int checks = 0;
    int fails  = 0;
    int ref_count = 0;
    bit ref_run = 1'b0;

    elapsed_timer u_elapsed_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .toggle_i  (toggle_i),
        .clear_i   (clear_i),
        .units_o   (units_o),
        .tens_o    (tens_o),
        .running_o (running_o)
    );

    always #5 clk = ~clk;

    task automatic compare(input string tag);
        int eu = ref_count % 10;
        int et = ref_count / 10;
        checks++;
        if (units_o !== 4'(eu) || tens_o !== 4'(et) || running_o !== ref_run) begin
            fails++;
            $display("FAIL %s: got tens=%0d units=%0d run=%0b, expected tens=%0d units=%0d run=%0b",
                     tag, tens_o, units_o, running_o, et, eu, ref_run);
        end
        checks++;
        if (units_o > 4'd9 || tens_o > 4'd5) begin
            fails++;
            $display("FAIL R6: got tens=%0d units=%0d, expected units<=9 tens<=5",
                     tens_o, units_o);
        end
    endtask

    task automatic cycle(input bit t, input bit g, input bit c);
        string tag;
        if (c)                                 tag = "R7";
        else if (t && ref_run && ref_count % 10 == 9) tag = "R5 R8";
        else if (t && ref_run)                 tag = "R4";
        else if (t)                            tag = "R3";
        else if (g)                            tag = "R2";
        else                                   tag = "R4 hold";
        tick_i = t; toggle_i = g; clear_i = c;
        @(posedge clk);
        if (c)                 ref_count = 0;
        else if (t && ref_run) ref_count = (ref_count + 1) % 60;
        if (g) ref_run = !ref_run;
        @(negedge clk);
        tick_i = 1'b0; toggle_i = 1'b0; clear_i = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        ref_count = 0; ref_run = 1'b0;
        compare("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got no completion, expected end of run");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R3: ticks before starting are ignored
        for (int i = 0; i < 4; i++) cycle(1, 0, 0);
        // R2: start
        cycle(0, 1, 0);
        // R4/R5/R8 sweep with stop intervals; covers several 59->00 wraps
        for (int i = 0; i < 200; i++) begin
            cycle(1, 0, 0);
            if (i % 5 == 0) cycle(0, 0, 0);
            if (i % 37 == 36) begin
                cycle(0, 1, 0);
                for (int k = 0; k < 3; k++) cycle(1, 0, 0);
                cycle(0, 1, 0);
            end
        end
        // Move to 47, then R7: clear beats a tick, run flag unchanged
        while (ref_count != 47) cycle(1, 0, 0);
        cycle(1, 0, 1);
        for (int i = 0; i < 12; i++) cycle(1, 0, 0);
        // R7: clear with toggle in the same cycle still stops
        cycle(0, 1, 1);
        cycle(1, 0, 0);
        // R2: toggle and tick together while stopped; tick uses old flag
        cycle(1, 1, 0);
        cycle(1, 1, 0);
        cycle(1, 0, 0);
        // R1: reset in the middle of a run clears digits and flag
        cycle(0, 1, 0);
        for (int i = 0; i < 15; i++) cycle(1, 0, 0);
        do_reset();
        cycle(1, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule